// File: doc/BRIEF.md
# DMA Latency Monitor

This block watches two handshakes at the back end of a DMA path and turns them into interval statistics. The first channel measures how long a data writer sits stalled before the DMA engine acknowledges that a buffer has reached host memory, which bounds the write rate. The second channel measures the spacing between successive descriptor issues, which bounds the rate at which data is drained to the host.

For each channel the block records the most recent interval, the largest interval, and a running sum plus a sample count from which software derives the mean. Software pulses a snapshot strobe at its readout period, typically once per second. That pulse copies all statistics into a shadow set in one cycle and clears the live accumulators, so every readout covers exactly one period. A small combinational read port selects one shadow field at a time. All counters hold at their maximum value instead of wrapping. At a 4 ns clock, a 16-bit interval counter covers about 262 us.

Top module: `dma_latency_monitor`

## Requirements
- R1: After reset every readable field is zero.
- R2: A stall episode opens in the first cycle where `wr_stall_i` is high while no episode is open. It closes in the first cycle where `dma_ack_i` is high, and that cycle is counted. The recorded interval equals the number of cycles from opening to closing, inclusive: stall and acknowledge together in one cycle record 1. Once open, the episode counts even if `wr_stall_i` drops.
- R3: `dma_ack_i` while no episode is open and `wr_stall_i` is low records nothing.
- R4: Each `desc_stb_i` pulse after the first records the distance in cycles from the previous pulse: back-to-back pulses record 1. The first pulse after reset records nothing.
- R5: A recorded interval never exceeds 2^CNT_W-1; longer intervals record exactly that value.
- R6: The maximum field holds the largest interval recorded since the previous snapshot.
- R7: The sum field adds every recorded interval and holds at 2^SUM_W-1. The count field adds one per record and holds at 2^NUM_W-1.
- R8: In a cycle with `snap_i` high, the shadow set loads the live statistics, including any record made in that same cycle. Live maximum, sum and count are then cleared. The latest-interval value is not cleared. Shadow values change only on `snap_i`.
- R9: `rd_data_o` shows the shadow field picked by `rd_addr_i` in the same cycle. Bit 2 selects the channel (0 = stall wait, 1 = descriptor gap). Bits 1:0 select the field (0 latest, 1 maximum, 2 sum, 3 count). The value is zero-extended to DATA_W.
- R10: The latest field holds the most recent interval recorded, across snapshots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stall_i | input | 1 | Writer is blocked waiting for an acknowledge |
| dma_ack_i | input | 1 | DMA acknowledge pulse |
| desc_stb_i | input | 1 | Descriptor issue strobe |
| snap_i | input | 1 | Snapshot-and-clear strobe |
| rd_addr_i | input | 3 | Shadow field select |
| rd_data_o | output | DATA_W | Selected shadow field, zero-extended |

## Verification
The bench builds the block with CNT_W = 6, SUM_W = 9 and NUM_W = 4, so intervals saturate at 63, sums at 511 and counts at 15. With these widths, a stall of a hundred cycles or a single snapshot period with twenty records drives every saturation boundary within a short run. The bench also covers stall-and-acknowledge in one cycle, back-to-back descriptors, and snapshots that coincide with a record. A random phase then mixes all inputs against the reference model.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;

  // Field codes on the low two bits of the read address
  typedef enum logic [1:0] {
    FLD_LAST = 2'd0,
    FLD_MAX  = 2'd1,
    FLD_SUM  = 2'd2,
    FLD_CNT  = 2'd3
  } stat_fld_e;

  localparam int CH_ACK = 0;
  localparam int CH_GAP = 1;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

endpackage

// File: rtl/lat_interval_tracker.sv
module lat_interval_tracker #(
  parameter int CNT_W    = 16,
  parameter bit GAP_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_i,
  input  logic             ev_stop_i,
  output logic             rec_vld_o,
  output logic [CNT_W-1:0] rec_val_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             open_q, open_d;
  logic [CNT_W-1:0] run_q, run_d, run_inc;
  logic             run_en;

  assign run_inc = (run_q == CNT_MAX) ? CNT_MAX : run_q + CNT_ONE;

  generate
    if (GAP_MODE) begin : g_gap
      // Interval restarts on each strobe; the first strobe only arms.
      always_comb begin
        rec_vld_o = ev_stop_i & open_q;
        rec_val_o = run_inc;
        open_d    = open_q | ev_start_i;
        run_d     = ev_start_i ? '0 : run_inc;
        run_en    = ev_start_i | open_q;
      end
    end else begin : g_ack
      // Episode opens on a stall, closes on the acknowledge cycle.
      logic             active;
      logic [CNT_W-1:0] cur;
      always_comb begin
        active    = open_q | ev_start_i;
        cur       = open_q ? run_inc : CNT_ONE;
        rec_vld_o = active & ev_stop_i;
        rec_val_o = cur;
        open_d    = active & ~ev_stop_i;
        run_d     = ev_stop_i ? '0 : cur;
        run_en    = active;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      run_q  <= '0;
    end else begin
      open_q <= open_d;
      if (run_en) begin
        run_q <= run_d;
      end
    end
  end

endmodule

// File: rtl/lat_stat_accum.sv
module lat_stat_accum #(
  parameter int CNT_W = 16,
  parameter int SUM_W = 48,
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_vld_i,
  input  logic [CNT_W-1:0] rec_val_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] snap_last_o,
  output logic [CNT_W-1:0] snap_max_o,
  output logic [SUM_W-1:0] snap_sum_o,
  output logic [NUM_W-1:0] snap_cnt_o
);

  localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};
  localparam logic [NUM_W-1:0] NUM_MAX = {NUM_W{1'b1}};
  localparam logic [NUM_W-1:0] NUM_ONE = {{(NUM_W-1){1'b0}}, 1'b1};
  localparam int               PAD_W   = SUM_W + 1 - CNT_W;

  logic [CNT_W-1:0] last_q, max_q;
  logic [SUM_W-1:0] sum_q;
  logic [NUM_W-1:0] cnt_q;

  logic [CNT_W-1:0] last_upd, max_upd, max_d;
  logic [SUM_W:0]   sum_ext;
  logic [SUM_W-1:0] sum_upd, sum_d;
  logic [NUM_W-1:0] cnt_upd, cnt_d;
  logic             live_en, last_en;

  // Update terms with this cycle's record folded in
  always_comb begin
    sum_ext  = {1'b0, sum_q} + {{PAD_W{1'b0}}, rec_val_i};
    last_upd = rec_vld_i ? rec_val_i : last_q;
    max_upd  = (rec_vld_i && (rec_val_i > max_q)) ? rec_val_i : max_q;
    sum_upd  = !rec_vld_i ? sum_q : (sum_ext[SUM_W] ? SUM_MAX : sum_ext[SUM_W-1:0]);
    cnt_upd  = (rec_vld_i && (cnt_q != NUM_MAX)) ? cnt_q + NUM_ONE : cnt_q;
  end

  // Live next state: cleared on snapshot
  always_comb begin
    live_en = rec_vld_i | snap_i;
    last_en = rec_vld_i;
    max_d   = snap_i ? '0 : max_upd;
    sum_d   = snap_i ? '0 : sum_upd;
    cnt_d   = snap_i ? '0 : cnt_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      max_q  <= '0;
      sum_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (last_en) begin
        last_q <= last_upd;
      end
      if (live_en) begin
        max_q <= max_d;
        sum_q <= sum_d;
        cnt_q <= cnt_d;
      end
    end
  end

  // Shadow set, loaded only by the snapshot strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_last_o <= '0;
      snap_max_o  <= '0;
      snap_sum_o  <= '0;
      snap_cnt_o  <= '0;
    end else if (snap_i) begin
      snap_last_o <= last_upd;
      snap_max_o  <= max_upd;
      snap_sum_o  <= sum_upd;
      snap_cnt_o  <= cnt_upd;
    end
  end

endmodule

// File: rtl/dma_latency_monitor.sv
module dma_latency_monitor
  import lat_mon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SUM_W = 48,
  parameter int NUM_W = 32,
  localparam int DATA_W = (SUM_W > NUM_W) ? SUM_W : NUM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stall_i,
  input  logic              dma_ack_i,
  input  logic              desc_stb_i,
  input  logic              snap_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [NUM_CH-1:0]  ev_start, ev_stop, rec_vld;
  logic [CNT_W-1:0]   rec_val   [NUM_CH];
  logic [CNT_W-1:0]   snap_last [NUM_CH];
  logic [CNT_W-1:0]   snap_max  [NUM_CH];
  logic [SUM_W-1:0]   snap_sum  [NUM_CH];
  logic [NUM_W-1:0]   snap_cnt  [NUM_CH];

  always_comb begin
    ev_start[CH_ACK] = wr_stall_i;
    ev_stop[CH_ACK]  = dma_ack_i;
    ev_start[CH_GAP] = desc_stb_i;
    ev_stop[CH_GAP]  = desc_stb_i;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      lat_interval_tracker #(
        .CNT_W   (CNT_W),
        .GAP_MODE(c == CH_GAP)
      ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start_i(ev_start[c]),
        .ev_stop_i (ev_stop[c]),
        .rec_vld_o (rec_vld[c]),
        .rec_val_o (rec_val[c])
      );

      lat_stat_accum #(
        .CNT_W(CNT_W),
        .SUM_W(SUM_W),
        .NUM_W(NUM_W)
      ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_vld_i  (rec_vld[c]),
        .rec_val_i  (rec_val[c]),
        .snap_i     (snap_i),
        .snap_last_o(snap_last[c]),
        .snap_max_o (snap_max[c]),
        .snap_sum_o (snap_sum[c]),
        .snap_cnt_o (snap_cnt[c])
      );
    end
  endgenerate

  // Read select: bit 2 channel, bits 1:0 field
  logic      rd_ch;
  stat_fld_e rd_fld;

  always_comb begin
    rd_ch     = rd_addr_i[2];
    rd_fld    = stat_fld_e'(rd_addr_i[1:0]);
    rd_data_o = '0;
    case (rd_fld)
      FLD_LAST: rd_data_o[CNT_W-1:0] = snap_last[rd_ch];
      FLD_MAX:  rd_data_o[CNT_W-1:0] = snap_max[rd_ch];
      FLD_SUM:  rd_data_o[SUM_W-1:0] = snap_sum[rd_ch];
      FLD_CNT:  rd_data_o[NUM_W-1:0] = snap_cnt[rd_ch];
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/lat_mon_checker.sv
module lat_mon_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stall_i,
  input logic              dma_ack_i,
  input logic              desc_stb_i,
  input logic              snap_i,
  input logic [2:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ack_rec_vld,
  input logic [CNT_W-1:0]  ack_rec_val,
  input logic              gap_rec_vld
);

  // R2
  stall_ack_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stall_i && dma_ack_i) |-> (ack_rec_vld && (ack_rec_val != '0)));

  // R3
  ack_rec_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rec_vld |-> dma_ack_i);

  // R4
  gap_rec_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_rec_vld |-> desc_stb_i);

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_i ##1 $stable(rd_addr_i)) |-> $stable(rd_data_o));

endmodule

bind dma_latency_monitor lat_mon_checker #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stall_i (wr_stall_i),
  .dma_ack_i  (dma_ack_i),
  .desc_stb_i (desc_stb_i),
  .snap_i     (snap_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .ack_rec_vld(rec_vld[0]),
  .ack_rec_val(rec_val[0]),
  .gap_rec_vld(rec_vld[1])
);

// File: tb/tb_dma_latency_monitor.sv
module tb_dma_latency_monitor;

  localparam int CNT_W  = 6;
  localparam int SUM_W  = 9;
  localparam int NUM_W  = 4;
  localparam int DATA_W = 9;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int SMAX   = (1 << SUM_W) - 1;
  localparam int NMAX   = (1 << NUM_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_stall = 1'b0, dma_ack = 1'b0, desc_stb = 1'b0, snap = 1'b0;
  logic [2:0]        rd_addr = 3'd0;
  logic [DATA_W-1:0] rd_data;

  always #4 clk = ~clk;

  dma_latency_monitor #(.CNT_W(CNT_W), .SUM_W(SUM_W), .NUM_W(NUM_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stall_i(wr_stall), .dma_ack_i(dma_ack),
    .desc_stb_i(desc_stb), .snap_i(snap), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // ---------------- behavioural reference ----------------
  int cyc;
  bit a_open; int a_start;
  bit g_seen; int g_last;
  int m_last[2], m_max[2], m_sum[2], m_cnt[2];
  int s_last[2], s_max[2], s_sum[2], s_cnt[2];

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic record(int ch, int v);
    m_last[ch] = v;
    if (v > m_max[ch]) m_max[ch] = v;
    m_sum[ch] = min2(m_sum[ch] + v, SMAX);
    m_cnt[ch] = min2(m_cnt[ch] + 1, NMAX);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; a_open = 0; a_start = 0; g_seen = 0; g_last = 0;
      for (int i = 0; i < 2; i++) begin
        m_last[i] = 0; m_max[i] = 0; m_sum[i] = 0; m_cnt[i] = 0;
        s_last[i] = 0; s_max[i] = 0; s_sum[i] = 0; s_cnt[i] = 0;
      end
    end else begin
      cyc++;
      if (!a_open && wr_stall) begin a_open = 1; a_start = cyc; end
      if (a_open && dma_ack) begin record(0, min2(cyc - a_start + 1, CMAX)); a_open = 0; end
      if (desc_stb) begin
        if (g_seen) record(1, min2(cyc - g_last, CMAX));
        g_seen = 1; g_last = cyc;
      end
      if (snap) begin
        for (int i = 0; i < 2; i++) begin
          s_last[i] = m_last[i]; s_max[i] = m_max[i]; s_sum[i] = m_sum[i]; s_cnt[i] = m_cnt[i];
          m_max[i] = 0; m_sum[i] = 0; m_cnt[i] = 0;
        end
      end
    end
  end

  // ---------------- checking ----------------
  int    vecs = 0, fails = 0;
  string phase = "R1";
  bit    done = 0;
  int    rot = 0;

  function automatic int expect_of(logic [2:0] a);
    int ch; ch = a[2];
    case (a[1:0])
      2'd0: return s_last[ch];
      2'd1: return s_max[ch];
      2'd2: return s_sum[ch];
      default: return s_cnt[ch];
    endcase
  endfunction

  function automatic string ftag(logic [2:0] a);
    case (a[1:0])
      2'd0: return "R9/R10";
      2'd1: return "R9/R6";
      default: return "R9/R7";
    endcase
  endfunction

  task automatic compare();
    int exp;
    if (rst_n) begin
      exp = expect_of(rd_addr);
      vecs++;
      if (int'(rd_data) != exp) begin
        fails++;
        $display("FAIL %s %s addr=%0d actual=%0d expected=%0d", phase, ftag(rd_addr),
                 rd_addr, rd_data, exp);
      end
    end
  endtask

  task automatic step(input logic st, input logic ak, input logic sb, input logic sn);
    @(negedge clk);
    compare();
    wr_stall = st; dma_ack = ak; desc_stb = sb; snap = sn;
    rd_addr = 3'(rot); rot++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic snap_read();
    step(0, 0, 0, 1);
    idle(16);
  endtask

  task automatic episode(int len);  // stall for len cycles, ack on the last
    for (int i = 1; i < len; i++) step(1, 0, 0, 0);
    step(1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on all eight fields
    phase = "R1";
    idle(16);

    // R2: stall episodes, single cycle and longer, stall dropping mid-episode
    phase = "R2";
    episode(1); idle(2);
    episode(5); idle(1);
    step(1, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 1, 0, 0);
    idle(2);
    episode(3);
    snap_read();

    // R3: stray acknowledges record nothing
    phase = "R3";
    step(0, 1, 0, 0); idle(2); step(0, 1, 0, 0); step(0, 1, 0, 0);
    snap_read();

    // R4: first strobe arms only, then gaps 1, 3, 10
    phase = "R4";
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    idle(2); step(0, 0, 1, 0);
    idle(9); step(0, 0, 1, 0);
    snap_read();

    // R5: interval saturation on both channels
    phase = "R5";
    episode(100);
    step(0, 0, 1, 0); idle(79); step(0, 0, 1, 0);
    snap_read();

    // R7: sum and count saturation
    phase = "R7";
    for (int k = 0; k < 20; k++) episode(30);
    snap_read();

    // R8: snapshot coinciding with records, then back-to-back snapshots
    phase = "R8";
    step(0, 0, 1, 0); idle(3);
    step(1, 1, 1, 1);
    idle(8);
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    idle(16);

    // mixed traffic
    phase = "R6";
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 9) == 0,
           ($urandom % 60) == 0);
    end
    snap_read();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog %s actual=hung expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule